// File: doc/BRIEF.md
# Serial FIFO extension interrupt controller

This block is the control and interrupt side of a large pair of external transmit and receive FIFOs that sit beside a 16550-style UART. A host reaches it through a five-register window: a mode register, an interrupt enable register, a status register whose address doubles as a write-only FIFO reset, a timer interval register and a timer control register. The FIFO storage itself, the UART and the bus bridge live elsewhere. The FIFO level flags, the push and pop strobes and a character-timeout event come in as inputs.

Five interrupt sources are tracked: receive half full, transmit half full, transmit empty, character timeout and a periodic hardware timer. Each source has its own clearing rule. Some clear on a status read, some on a FIFO access, and the timer clears only when it is disabled. The enabled pending sources are merged onto a single interrupt line. In level form the line is held; in edge form it gives one pulse each time a source becomes active. The timer counts in steps of a prescaled tick (0.2 ms at the default clock divider) and fires every n steps while enabled.

Top module: `fifo_ext_irq_ctrl`

## Requirements
- R1: After reset every register reads 0. Offsets are: 0 mode, 1 interrupt enable, 2 status, 3 timer interval, 4 timer control. Mode keeps bits 4, 3, 2 and 0; bit 1 and bits 7:5 read 0. Enable keeps bits 4:0, the interval keeps all 8 bits and timer control keeps bit 0. Offsets 5 to 7 read 0. Read data appears on the cycle after the read strobe.
- R2: A status read returns: bit 7 timer pending, bit 6 character-timeout pending, bit 5 the inverse of rx_full, bit 4 rx_half, bit 3 rx_empty, bit 2 tx_full, bit 1 tx_half, bit 0 tx_empty.
- R3: Mode bit 3 drives auto_flow_en, bit 2 drives ext_fifo_en and bit 0 drives swap_halves. Mode bit 4 selects the interrupt form: 1 is level, 0 is edge.
- R4: A write to offset 2 raises tx_fifo_rst and rx_fifo_rst together for exactly the one cycle after the write, and changes no register.
- R5: With the interval set to n (0 counts as 1), setting timer-control bit 0 makes the timer expire every n × TICK_DIV clocks. In level form with only the timer enabled (enable bit 4), irq rises n × TICK_DIV + 2 clocks after the enabling write edge.
- R6: A pending timer interrupt survives status reads and is cleared only by clearing timer-control bit 0.
- R7: A char_timeout pulse sets the character-timeout pending bit (enable bit 3). An rx_pop or a status read clears it.
- R8: A rising edge of tx_empty sets the transmit-empty pending bit (enable bit 2). A tx_push or a status read clears it.
- R9: A falling edge of tx_half sets the transmit-half pending bit (enable bit 1). A rising tx_half or a status read clears it.
- R10: The receive-half pending bit (enable bit 0) follows rx_half one cycle late. A status read does not clear it.
- R11: In level form, irq is the registered OR of the enabled pending bits. It changes one cycle after the pending bits change.
- R12: In edge form, irq is a one-cycle pulse on the cycle after an enabled source becomes active. A source that stays active gives no further pulse.
- R13: A pending source whose enable bit is 0 never raises irq, but still shows in status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Register offset |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| tx_empty | input | 1 | Transmit FIFO empty flag |
| tx_half | input | 1 | Transmit FIFO at or above half full |
| tx_full | input | 1 | Transmit FIFO full flag |
| rx_empty | input | 1 | Receive FIFO empty flag |
| rx_half | input | 1 | Receive FIFO at or above half full |
| rx_full | input | 1 | Receive FIFO full flag |
| tx_push | input | 1 | Transmit FIFO write strobe |
| rx_pop | input | 1 | Receive FIFO read strobe |
| char_timeout | input | 1 | Character-timeout event pulse |
| irq | output | 1 | Combined interrupt line |
| tx_fifo_rst | output | 1 | Transmit FIFO reset pulse |
| rx_fifo_rst | output | 1 | Receive FIFO reset pulse |
| auto_flow_en | output | 1 | Automatic RTS/CTS flow control enable |
| ext_fifo_en | output | 1 | External FIFO enable |
| swap_halves | output | 1 | Swap upper and lower 8 bytes of the 16-byte window |

## Verification
The bench builds the block with TICK_DIV = 4. At that setting one timer step is four clocks, so the exact cycle on which irq rises can be checked for interval 3 and for interval 0, which counts as 1. The default divider of 20000 would put even one period out of reach. With a small divider the timer also keeps running while the other sources are exercised, so the bench can confirm that status reads leave the timer interrupt in place.

// File: rtl/fxi_pkg.sv
package fxi_pkg;
  localparam int AW    = 3;
  localparam int DW    = 8;
  localparam int NSRC  = 5;

  typedef enum logic [AW-1:0] {
    OFS_MODE = 3'd0,
    OFS_IEN  = 3'd1,
    OFS_STAT = 3'd2,
    OFS_TIVL = 3'd3,
    OFS_TCTL = 3'd4
  } reg_ofs_e;

  // interrupt source bit positions (enable and pending vectors)
  localparam int SRC_RXH = 0;
  localparam int SRC_TXH = 1;
  localparam int SRC_TXE = 2;
  localparam int SRC_CTO = 3;
  localparam int SRC_TMR = 4;

  // mode register bit positions
  localparam int MB_SWAP  = 0;
  localparam int MB_RSVD  = 1;
  localparam int MB_FIFO  = 2;
  localparam int MB_FLOW  = 3;
  localparam int MB_LEVEL = 4;
  localparam int MODE_W   = 5;
endpackage

// File: rtl/fxi_regs.sv
module fxi_regs
  import fxi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     status_in,
  output logic [DW-1:0]     rdata,
  output logic [MODE_W-1:0] mode_q,
  output logic [NSRC-1:0]   ien_q,
  output logic [DW-1:0]     tivl_q,
  output logic              tmr_en_q,
  output logic              stat_rd,
  output logic              fifo_rst_q
);
  logic stat_wr;

  assign stat_rd = rd && (addr == OFS_STAT);
  assign stat_wr = wr && (addr == OFS_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= '0;
      ien_q      <= '0;
      tivl_q     <= '0;
      tmr_en_q   <= 1'b0;
      fifo_rst_q <= 1'b0;
      rdata      <= '0;
    end else begin
      fifo_rst_q <= stat_wr;
      if (wr) begin
        case (addr)
          OFS_MODE: begin
            mode_q          <= wdata[MODE_W-1:0];
            mode_q[MB_RSVD] <= 1'b0;
          end
          OFS_IEN:  ien_q    <= wdata[NSRC-1:0];
          OFS_TIVL: tivl_q   <= wdata;
          OFS_TCTL: tmr_en_q <= wdata[0];
          default: ;
        endcase
      end
      if (rd) begin
        case (addr)
          OFS_MODE: rdata <= DW'(mode_q);
          OFS_IEN:  rdata <= DW'(ien_q);
          OFS_STAT: rdata <= status_in;
          OFS_TIVL: rdata <= tivl_q;
          OFS_TCTL: rdata <= DW'(tmr_en_q);
          default:  rdata <= '0;
        endcase
      end
    end
  end

  a_r4_rst_one_cycle: assert property (@(posedge clk) disable iff (rst)
    fifo_rst_q |=> !fifo_rst_q);
  a_r4_rst_from_write: assert property (@(posedge clk) disable iff (rst)
    fifo_rst_q |-> $past(stat_wr));
  a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    !mode_q[MB_RSVD]);
endmodule

// File: rtl/fxi_timer.sv
module fxi_timer #(
  parameter int TICK_DIV = 20000,
  parameter int IVL_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [IVL_W-1:0] ivl,
  output logic             expire
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0]    pre_q;
  logic [IVL_W-1:0] cnt_q;
  logic [IVL_W-1:0] ivl_eff;

  assign ivl_eff = (ivl == '0) ? IVL_W'(1) : ivl;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      cnt_q  <= IVL_W'(1);
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (!en) begin
        pre_q <= '0;
        cnt_q <= ivl_eff;
      end else if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        if (cnt_q == IVL_W'(1)) begin
          cnt_q  <= ivl_eff;
          expire <= 1'b1;
        end else begin
          cnt_q <= cnt_q - IVL_W'(1);
        end
      end else begin
        pre_q <= pre_q + PW'(1);
      end
    end
  end

  a_r5_cnt_nonzero: assert property (@(posedge clk) disable iff (rst)
    cnt_q != '0);
  a_r5_expire_needs_en: assert property (@(posedge clk) disable iff (rst)
    expire |-> $past(en));
endmodule

// File: rtl/fxi_irq.sv
module fxi_irq
  import fxi_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            tx_empty,
  input  logic            tx_half,
  input  logic            rx_half,
  input  logic            tx_push,
  input  logic            rx_pop,
  input  logic            char_timeout,
  input  logic            stat_rd,
  input  logic            tmr_expire,
  input  logic            tmr_en,
  input  logic [NSRC-1:0] ien,
  input  logic            level_mode,
  output logic [NSRC-1:0] pend,
  output logic            irq
);
  logic            txe_prev, txh_prev;
  logic [NSRC-1:0] active, act_prev;
  logic            txe_set;

  assign active  = pend & ien;
  assign txe_set = tx_empty & ~txe_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= '0;
      txe_prev <= 1'b1;
      txh_prev <= 1'b0;
      act_prev <= '0;
      irq      <= 1'b0;
    end else begin
      txe_prev <= tx_empty;
      txh_prev <= tx_half;

      if (!tmr_en)         pend[SRC_TMR] <= 1'b0;
      else if (tmr_expire) pend[SRC_TMR] <= 1'b1;

      if (char_timeout)          pend[SRC_CTO] <= 1'b1;
      else if (rx_pop || stat_rd) pend[SRC_CTO] <= 1'b0;

      if (txe_set)                 pend[SRC_TXE] <= 1'b1;
      else if (tx_push || stat_rd) pend[SRC_TXE] <= 1'b0;

      if (!tx_half && txh_prev)    pend[SRC_TXH] <= 1'b1;
      else if (tx_half || stat_rd) pend[SRC_TXH] <= 1'b0;

      pend[SRC_RXH] <= rx_half;

      act_prev <= active;
      irq      <= level_mode ? (|active) : (|(active & ~act_prev));
    end
  end

  a_r6_tmr_hold: assert property (@(posedge clk) disable iff (rst)
    (pend[SRC_TMR] && tmr_en) |=> pend[SRC_TMR]);
  a_r8_txe_clear: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !txe_set) |=> !pend[SRC_TXE]);
  a_r11_level_or: assert property (@(posedge clk) disable iff (rst)
    (level_mode && $past(level_mode)) |-> (irq == $past(|active)));
  a_r13_no_enable: assert property (@(posedge clk) disable iff (rst)
    ($past(active) == '0) |-> !irq);
endmodule

// File: rtl/fifo_ext_irq_ctrl.sv
module fifo_ext_irq_ctrl
  import fxi_pkg::*;
#(
  parameter int TICK_DIV = 20000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          tx_empty,
  input  logic          tx_half,
  input  logic          tx_full,
  input  logic          rx_empty,
  input  logic          rx_half,
  input  logic          rx_full,
  input  logic          tx_push,
  input  logic          rx_pop,
  input  logic          char_timeout,
  output logic          irq,
  output logic          tx_fifo_rst,
  output logic          rx_fifo_rst,
  output logic          auto_flow_en,
  output logic          ext_fifo_en,
  output logic          swap_halves
);
  logic [MODE_W-1:0] mode_q;
  logic [NSRC-1:0]   ien_q, pend;
  logic [DW-1:0]     tivl_q, status;
  logic              tmr_en_q, stat_rd, fifo_rst_q, tmr_expire;

  assign status = {pend[SRC_TMR], pend[SRC_CTO], ~rx_full, rx_half,
                   rx_empty, tx_full, tx_half, tx_empty};

  fxi_regs u_regs (
    .clk(clk), .rst(rst), .addr(host_addr), .wr(host_wr), .rd(host_rd),
    .wdata(host_wdata), .status_in(status), .rdata(host_rdata),
    .mode_q(mode_q), .ien_q(ien_q), .tivl_q(tivl_q), .tmr_en_q(tmr_en_q),
    .stat_rd(stat_rd), .fifo_rst_q(fifo_rst_q)
  );

  fxi_timer #(.TICK_DIV(TICK_DIV), .IVL_W(DW)) u_timer (
    .clk(clk), .rst(rst), .en(tmr_en_q), .ivl(tivl_q), .expire(tmr_expire)
  );

  fxi_irq u_irq (
    .clk(clk), .rst(rst), .tx_empty(tx_empty), .tx_half(tx_half),
    .rx_half(rx_half), .tx_push(tx_push), .rx_pop(rx_pop),
    .char_timeout(char_timeout), .stat_rd(stat_rd), .tmr_expire(tmr_expire),
    .tmr_en(tmr_en_q), .ien(ien_q), .level_mode(mode_q[MB_LEVEL]),
    .pend(pend), .irq(irq)
  );

  assign tx_fifo_rst  = fifo_rst_q;
  assign rx_fifo_rst  = fifo_rst_q;
  assign auto_flow_en = mode_q[MB_FLOW];
  assign ext_fifo_en  = mode_q[MB_FIFO];
  assign swap_halves  = mode_q[MB_SWAP];
endmodule

// File: tb/fifo_ext_irq_ctrl_tb.sv
module fifo_ext_irq_ctrl_tb;
  localparam int TDIV = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] host_addr = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic tx_empty = 1'b1, tx_half = 1'b0, tx_full = 1'b0;
  logic rx_empty = 1'b1, rx_half = 1'b0, rx_full = 1'b0;
  logic tx_push = 1'b0, rx_pop = 1'b0, char_timeout = 1'b0;
  logic irq, tx_fifo_rst, rx_fifo_rst, auto_flow_en, ext_fifo_en, swap_halves;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fifo_ext_irq_ctrl #(.TICK_DIV(TDIV)) u_dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_empty(tx_empty), .tx_half(tx_half), .tx_full(tx_full),
    .rx_empty(rx_empty), .rx_half(rx_half), .rx_full(rx_full),
    .tx_push(tx_push), .rx_pop(rx_pop), .char_timeout(char_timeout),
    .irq(irq), .tx_fifo_rst(tx_fifo_rst), .rx_fifo_rst(rx_fifo_rst),
    .auto_flow_en(auto_flow_en), .ext_fifo_en(ext_fifo_en),
    .swap_halves(swap_halves)
  );

  // {offset, write data, expected readback}
  localparam int NV = 8;
  localparam logic [18:0] VEC [NV] = '{
    {3'd0, 8'hFF, 8'h1D}, {3'd1, 8'hFF, 8'h1F}, {3'd3, 8'hA5, 8'hA5},
    {3'd4, 8'hFF, 8'h01}, {3'd4, 8'h00, 8'h00}, {3'd0, 8'h02, 8'h00},
    {3'd1, 8'h0A, 8'h0A}, {3'd3, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0; d = host_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    cyc(3); rst = 1'b0; cyc(1);

    // R1 reset state
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    chk("R4 reset fifo rst", {6'b0, tx_fifo_rst, rx_fifo_rst}, 8'h00);
    rd(3'd0, d); chk("R1 reset mode", d, 8'h00);
    rd(3'd1, d); chk("R1 reset ien", d, 8'h00);
    rd(3'd4, d); chk("R1 reset tctl", d, 8'h00);

    // R1 table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], d);
      chk("R1 readback", d, VEC[i][7:0]);
    end
    rd(3'd6, d); chk("R1 unmapped", d, 8'h00);

    // R3 mode pins
    wr(3'd0, 8'h0D);
    chk("R3 mode pins", {5'b0, auto_flow_en, ext_fifo_en, swap_halves}, 8'h07);
    wr(3'd0, 8'h08);
    chk("R3 mode pins flow only", {5'b0, auto_flow_en, ext_fifo_en, swap_halves}, 8'h04);

    // R2 status layout
    rd(3'd2, d); chk("R2 status idle", d, 8'h29);
    tx_empty = 1'b0; rx_empty = 1'b0; rx_full = 1'b1; rx_half = 1'b1;
    tx_full = 1'b1; tx_half = 1'b1;
    cyc(2);
    rd(3'd2, d); chk("R2 status busy", d, 8'h16);
    tx_full = 1'b0; rx_full = 1'b0; rx_half = 1'b0; rx_empty = 1'b1;
    cyc(2);

    // R4 FIFO reset pulse, mode untouched
    wr(3'd2, 8'hFF);
    chk("R4 rst pulse", {6'b0, tx_fifo_rst, rx_fifo_rst}, 8'h03);
    cyc(1);
    chk("R4 rst ends", {6'b0, tx_fifo_rst, rx_fifo_rst}, 8'h00);
    rd(3'd0, d); chk("R4 mode kept", d, 8'h08);

    // R12 edge form, tx empty (mode bit4 = 0)
    wr(3'd0, 8'h00); wr(3'd1, 8'h04);
    tx_empty = 1'b1; cyc(1);
    chk("R12 not yet", {7'b0, irq}, 8'h00);
    cyc(1); chk("R12 pulse", {7'b0, irq}, 8'h01);
    cyc(1); chk("R12 pulse ends", {7'b0, irq}, 8'h00);
    cyc(2); chk("R12 no repeat", {7'b0, irq}, 8'h00);

    // R8 / R11 level form: tx_push clears
    wr(3'd0, 8'h10);
    cyc(1); chk("R11 level held", {7'b0, irq}, 8'h01);
    @(negedge clk); tx_push = 1'b1; @(negedge clk); tx_push = 1'b0;
    cyc(1); chk("R8 push clears", {7'b0, irq}, 8'h00);
    tx_empty = 1'b0; cyc(1); tx_empty = 1'b1; cyc(2);
    chk("R8 set again", {7'b0, irq}, 8'h01);
    rd(3'd2, d); cyc(1);
    chk("R8 status read clears", {7'b0, irq}, 8'h00);

    // R9 tx half
    wr(3'd1, 8'h02);
    tx_half = 1'b0; cyc(3);
    chk("R9 falling sets", {7'b0, irq}, 8'h01);
    tx_half = 1'b1; cyc(3);
    chk("R9 rising clears", {7'b0, irq}, 8'h00);
    tx_half = 1'b0; cyc(3);
    rd(3'd2, d); cyc(1);
    chk("R9 status read clears", {7'b0, irq}, 8'h00);

    // R7 char timeout
    wr(3'd1, 8'h08);
    @(negedge clk); char_timeout = 1'b1; @(negedge clk); char_timeout = 1'b0;
    cyc(1); chk("R7 set", {7'b0, irq}, 8'h01);
    rd(3'd2, d); chk("R7 status bit6", d & 8'h40, 8'h40);
    cyc(1); chk("R7 status read clears", {7'b0, irq}, 8'h00);
    @(negedge clk); char_timeout = 1'b1; @(negedge clk); char_timeout = 1'b0;
    @(negedge clk); rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
    cyc(1); chk("R7 pop clears", {7'b0, irq}, 8'h00);

    // R10 rx half
    wr(3'd1, 8'h01);
    rx_half = 1'b1; cyc(3);
    chk("R10 set", {7'b0, irq}, 8'h01);
    rd(3'd2, d); cyc(2);
    chk("R10 read keeps", {7'b0, irq}, 8'h01);
    rx_half = 1'b0; cyc(3);
    chk("R10 below half clears", {7'b0, irq}, 8'h00);

    // R13 disabled source
    wr(3'd1, 8'h00);
    @(negedge clk); char_timeout = 1'b1; @(negedge clk); char_timeout = 1'b0;
    cyc(3); chk("R13 masked irq", {7'b0, irq}, 8'h00);
    rd(3'd2, d); chk("R13 still pending", d & 8'h40, 8'h40);

    // R5 timer, n = 3
    wr(3'd1, 8'h10); wr(3'd3, 8'h03); wr(3'd4, 8'h01);
    cyc(3 * TDIV + 1); chk("R5 before expiry", {7'b0, irq}, 8'h00);
    cyc(1);            chk("R5 at expiry", {7'b0, irq}, 8'h01);
    // R6 status read keeps it
    rd(3'd2, d); chk("R6 status bit7", d & 8'h80, 8'h80);
    cyc(1); chk("R6 read keeps", {7'b0, irq}, 8'h01);
    wr(3'd4, 8'h00); cyc(2);
    chk("R6 disable clears", {7'b0, irq}, 8'h00);

    // R5 interval 0 counts as 1
    wr(3'd3, 8'h00); wr(3'd4, 8'h01);
    cyc(TDIV + 1); chk("R5 zero before", {7'b0, irq}, 8'h00);
    cyc(1);        chk("R5 zero expiry", {7'b0, irq}, 8'h01);
    wr(3'd4, 8'h00); cyc(2);

    finish_run();
  end
endmodule